// File: doc/BRIEF.md
# Pipelined Digit-Serial Montgomery Multiplier

This block computes a Montgomery product R ≡ A·B·r^(−n) (mod M) with radix r = 2^k, using a linear chain of n digit cells that only talk to their immediate neighbours. The operands B and M, and the negated inverse of the low digit of M modulo r, are loaded into holding registers beforehand. The digits of A then stream in one at a time, least significant first. Each digit opens one iteration. In that iteration, a_i·B and a chosen multiple q_i·M are added so that the lowest digit becomes zero, and the sum is shifted down by one digit.

The quotient digit is formed in the lowest cell and travels up the chain together with a_i. Cell j works on iteration i at cycle 2i+j after the digit is accepted. Carries move upward by one cell per cycle, and each cell reads the previous iteration's digit from the cell above it. A digit may be accepted at most once every two cycles. The first digit of a new multiplication may follow the last digit of the previous one with no extra pause. Result digits leave the chain lowest first, one per cycle, and a completion pulse marks the top digit. If the top digit of A is zero, B < 2M and 2rM < r^n, the result stays below 2M, so it can be fed straight back as an operand.

Top module: `mont_sys_mul`

## Requirements
- R1: While reset is held, and after it is released until a multiplication finishes, res_vld_o and done_o stay low.
- R2: For odd M, with every top-level operand precondition met, the assembled result R satisfies R·2^(k·n) ≡ A·B (mod M). Here A is the n accepted digits, least significant first, and R is the sum of res_dig_o·2^(k·res_pos_o).
- R3: Under the same preconditions (B < 2M, 2·2^k·M < 2^(k·n), top digit of A zero), R < 2M.
- R4: A digit offered in the cycle directly after an accepted digit is dropped and has no effect on the result. The next cycle's offer is accepted.
- R5: Result digits appear on consecutive cycles in ascending res_pos_o order, 0 to n−1. Position p is valid in the cycle after the (p+1)-th rising edge that follows the edge accepting the last A digit.
- R6: done_o is high for exactly one cycle. That cycle is the one carrying res_pos_o = n−1, and done_o is never high with any other position.
- R7: The first digit of a new multiplication may be accepted two cycles after the last digit of the previous one, and both results meet R2 and R3.
- R8: A load pulse captures B, M and the negated inverse. The block forms the b0 quotient constant itself, and later multiplications use the new operands.
- R9: Gaps of more than two cycles between accepted digits leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ld_i | input | 1 | Load pulse for the operand registers |
| cfg_b_i | input | k·n | Operand B |
| cfg_m_i | input | k·n | Odd modulus M |
| cfg_ninv_i | input | k | (−M⁻¹) mod 2^k, taken from the low digit of M |
| a_vld_i | input | 1 | A digit offered |
| a_dig_i | input | k | A digit value |
| res_vld_o | output | 1 | Result digit valid |
| res_pos_o | output | log2 n | Digit position of res_dig_o |
| res_dig_o | output | k | Result digit |
| done_o | output | 1 | Top result digit present; multiplication complete |

## Verification
Two things can share a cycle. The lowest cells can start the first iterations of a new multiplication while the upper cells are still computing, or draining, the last iteration of the previous one. This is provoked by streaming the next A directly after the previous one, with two-cycle spacing, and by a burst that offers a digit every cycle. Each result is judged by the congruence with 2^(k·n), by the bound below 2M, and by the cycle at which each position emerges, counted from the accepting edge of the last digit.

// File: rtl/mont_sys_pkg.sv
package mont_sys_pkg;
  parameter int unsigned DW    = 4;
  parameter int unsigned NCELL = 8;

  localparam int unsigned OPW = DW * NCELL;
  localparam int unsigned CW  = DW + 1;
  localparam int unsigned PW  = 2 * DW;
  localparam int unsigned SW  = 2 * DW + 2;
  localparam int unsigned PSW = (NCELL > 1) ? $clog2(NCELL) : 1;

  typedef logic [DW-1:0] dig_t;
  typedef logic [CW-1:0] cry_t;

  // work token that climbs the chain, one iteration per token
  typedef struct packed {
    logic vld;
    logic fst;
    logic lst;
    dig_t a;
    dig_t q;
  } tok_t;
endpackage

// File: rtl/mont_sys_seq.sv
module mont_sys_seq
  import mont_sys_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_vld_i,
  input  dig_t a_dig_i,
  output tok_t tok_o,
  output logic acc_o
);
  logic             hold_q, hold_d;
  logic [PSW-1:0]   cnt_q, cnt_d;
  logic             last_c;

  always_comb begin
    acc_o     = a_vld_i & ~hold_q;
    last_c    = (cnt_q == PSW'(NCELL - 1));
    hold_d    = acc_o;
    cnt_d     = cnt_q;
    if (acc_o) cnt_d = last_c ? '0 : cnt_q + 1'b1;
    tok_o.vld = acc_o;
    tok_o.fst = (cnt_q == '0);
    tok_o.lst = last_c;
    tok_o.a   = a_dig_i;
    tok_o.q   = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      if (acc_o) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mont_sys_qcell.sv
module mont_sys_qcell
  import mont_sys_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  tok_t tok_i,
  input  dig_t rin_i,
  input  dig_t b0_i,
  input  dig_t m0_i,
  input  dig_t ninv_i,
  input  dig_t bterm_i,
  output tok_t tok_o,
  output cry_t cry_o
);
  tok_t           tok_q, tok_d;
  cry_t           cry_q, cry_d;
  dig_t           rsel_c, q_c;
  logic [PW-1:0]  qp_c;
  logic [SW-1:0]  s_c;

  always_comb begin
    rsel_c = tok_i.fst ? '0 : rin_i;
    // quotient digit: makes the low digit of the iteration sum zero
    qp_c   = PW'(rsel_c) * PW'(ninv_i) + PW'(tok_i.a) * PW'(bterm_i);
    q_c    = qp_c[DW-1:0];
    s_c    = SW'(rsel_c) + SW'(tok_i.a) * SW'(b0_i) + SW'(q_c) * SW'(m0_i);
    tok_d   = tok_i;
    tok_d.q = q_c;
    cry_d   = s_c[DW +: CW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= '0;
      cry_q <= '0;
    end else begin
      tok_q.vld <= tok_i.vld;
      if (tok_i.vld) begin
        tok_q <= tok_d;
        cry_q <= cry_d;
      end
    end
  end

  assign tok_o = tok_q;
  assign cry_o = cry_q;
endmodule

// File: rtl/mont_sys_cell.sv
module mont_sys_cell
  import mont_sys_pkg::*;
#(
  parameter bit TOP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  tok_t tok_i,
  input  cry_t cry_i,
  input  dig_t rin_i,
  input  dig_t b_i,
  input  dig_t m_i,
  output tok_t tok_o,
  output cry_t cry_o,
  output dig_t dig_o,
  output dig_t hi_o
);
  tok_t          tok_q;
  cry_t          cry_q, cry_d;
  dig_t          dig_q, dig_d;
  dig_t          hi_q;
  dig_t          rup_c;
  logic [SW-1:0] s_c;

  always_comb begin
    rup_c = tok_i.fst ? '0 : (TOP ? hi_q : rin_i);
    s_c   = SW'(rup_c) + SW'(cry_i) + SW'(tok_i.a) * SW'(b_i) + SW'(tok_i.q) * SW'(m_i);
    dig_d = s_c[DW-1:0];
    cry_d = s_c[DW +: CW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= '0;
      cry_q <= '0;
      dig_q <= '0;
    end else begin
      tok_q.vld <= tok_i.vld;
      if (tok_i.vld) begin
        tok_q <= tok_i;
        cry_q <= cry_d;
        dig_q <= dig_d;
      end
    end
  end

  generate
    if (TOP) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hi_q <= '0;
        else if (tok_i.vld) hi_q <= s_c[DW +: DW];
      end
    end else begin : g_nohi
      assign hi_q = '0;
    end
  endgenerate

  assign tok_o = tok_q;
  assign cry_o = cry_q;
  assign dig_o = dig_q;
  assign hi_o  = hi_q;
endmodule

// File: rtl/mont_sys_drain.sv
module mont_sys_drain
  import mont_sys_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCELL-1:0] fin_i,
  input  dig_t             dig_i [NCELL],
  input  dig_t             hi_i,
  output logic             res_vld_o,
  output logic [PSW-1:0]   res_pos_o,
  output dig_t             res_dig_o,
  output logic             done_o
);
  logic tfl_q, tfl_d;

  always_comb begin
    tfl_d     = fin_i[NCELL-1];
    res_vld_o = 1'b0;
    res_pos_o = '0;
    res_dig_o = '0;
    for (int j = 1; j < NCELL; j++) begin
      if (fin_i[j]) begin
        res_vld_o = 1'b1;
        res_pos_o = PSW'(j - 1);
        res_dig_o = dig_i[j];
      end
    end
    if (tfl_q) begin
      res_vld_o = 1'b1;
      res_pos_o = PSW'(NCELL - 1);
      res_dig_o = hi_i;
    end
    done_o = tfl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tfl_q <= 1'b0;
    else         tfl_q <= tfl_d;
  end
endmodule

// File: rtl/mont_sys_mul.sv
module mont_sys_mul
  import mont_sys_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_ld_i,
  input  logic [OPW-1:0] cfg_b_i,
  input  logic [OPW-1:0] cfg_m_i,
  input  logic [DW-1:0]  cfg_ninv_i,
  input  logic           a_vld_i,
  input  logic [DW-1:0]  a_dig_i,
  output logic           res_vld_o,
  output logic [PSW-1:0] res_pos_o,
  output logic [DW-1:0]  res_dig_o,
  output logic           done_o
);
  logic rs_meta_q, rs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {rs_n_q, rs_meta_q} <= 2'b00;
    else         {rs_n_q, rs_meta_q} <= {rs_meta_q, 1'b1};
  end

  logic [OPW-1:0] b_q, m_q;
  dig_t           ninv_q, bt_q, bt_d;
  logic [PW-1:0]  btp_c;

  always_comb begin
    btp_c = PW'(cfg_b_i[DW-1:0]) * PW'(cfg_ninv_i);
    bt_d  = btp_c[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rs_n_q) begin
    if (!rs_n_q) begin
      b_q    <= '0;
      m_q    <= '0;
      ninv_q <= '0;
      bt_q   <= '0;
    end else if (cfg_ld_i) begin
      b_q    <= cfg_b_i;
      m_q    <= cfg_m_i;
      ninv_q <= cfg_ninv_i;
      bt_q   <= bt_d;
    end
  end

  tok_t             tok_in;
  logic             a_acc;
  tok_t             tok [NCELL];
  cry_t             cry [NCELL];
  dig_t             dig [NCELL];
  dig_t             hi  [NCELL];
  logic [NCELL-1:0] fin;

  mont_sys_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rs_n_q),
    .a_vld_i (a_vld_i),
    .a_dig_i (a_dig_i),
    .tok_o   (tok_in),
    .acc_o   (a_acc)
  );

  assign dig[0] = '0;
  assign hi[0]  = '0;

  mont_sys_qcell u_qcell (
    .clk_i   (clk_i),
    .rst_ni  (rs_n_q),
    .tok_i   (tok_in),
    .rin_i   (dig[1]),
    .b0_i    (b_q[DW-1:0]),
    .m0_i    (m_q[DW-1:0]),
    .ninv_i  (ninv_q),
    .bterm_i (bt_q),
    .tok_o   (tok[0]),
    .cry_o   (cry[0])
  );

  generate
    for (genvar j = 1; j < NCELL; j++) begin : g_cell
      if (j == NCELL - 1) begin : g_top
        mont_sys_cell #(.TOP(1'b1)) u_cell (
          .clk_i  (clk_i),
          .rst_ni (rs_n_q),
          .tok_i  (tok[j-1]),
          .cry_i  (cry[j-1]),
          .rin_i  ('0),
          .b_i    (b_q[j*DW +: DW]),
          .m_i    (m_q[j*DW +: DW]),
          .tok_o  (tok[j]),
          .cry_o  (cry[j]),
          .dig_o  (dig[j]),
          .hi_o   (hi[j])
        );
      end else begin : g_mid
        mont_sys_cell #(.TOP(1'b0)) u_cell (
          .clk_i  (clk_i),
          .rst_ni (rs_n_q),
          .tok_i  (tok[j-1]),
          .cry_i  (cry[j-1]),
          .rin_i  (dig[j+1]),
          .b_i    (b_q[j*DW +: DW]),
          .m_i    (m_q[j*DW +: DW]),
          .tok_o  (tok[j]),
          .cry_o  (cry[j]),
          .dig_o  (dig[j]),
          .hi_o   (hi[j])
        );
      end
    end
    for (genvar j = 0; j < NCELL; j++) begin : g_fin
      assign fin[j] = tok[j].vld & tok[j].lst;
    end
  endgenerate

  mont_sys_drain u_drain (
    .clk_i     (clk_i),
    .rst_ni    (rs_n_q),
    .fin_i     (fin),
    .dig_i     (dig),
    .hi_i      (hi[NCELL-1]),
    .res_vld_o (res_vld_o),
    .res_pos_o (res_pos_o),
    .res_dig_o (res_dig_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/mont_sys_mul_chk.sv
module mont_sys_mul_chk
  import mont_sys_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           a_acc_i,
  input logic           res_vld_o,
  input logic [PSW-1:0] res_pos_o,
  input logic           done_o
);
  p_acc_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_acc_i |=> !a_acc_i);

  p_done_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_vld_o && res_pos_o == PSW'(NCELL - 1)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pos_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !done_o) |=> (res_vld_o && res_pos_o == $past(res_pos_o) + 1'b1));

  p_pos_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_vld_o) |-> (res_pos_o == '0));
endmodule

bind mont_sys_mul mont_sys_mul_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_acc_i   (a_acc),
  .res_vld_o (res_vld_o),
  .res_pos_o (res_pos_o),
  .done_o    (done_o)
);

// File: tb/mont_sys_mul_tb_top.sv
module mont_sys_mul_tb_top;
  import mont_sys_pkg::*;
  localparam int unsigned N = NCELL;
  localparam int unsigned K = DW;

  logic           clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           cfg_ld;
  logic [OPW-1:0] cfg_b, cfg_m;
  logic [K-1:0]   cfg_ninv;
  logic           a_vld;
  logic [K-1:0]   a_dig;
  logic           res_vld;
  logic [PSW-1:0] res_pos;
  logic [K-1:0]   res_dig;
  logic           done;

  mont_sys_mul dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ld_i(cfg_ld), .cfg_b_i(cfg_b), .cfg_m_i(cfg_m),
    .cfg_ninv_i(cfg_ninv), .a_vld_i(a_vld), .a_dig_i(a_dig), .res_vld_o(res_vld),
    .res_pos_o(res_pos), .res_dig_o(res_dig), .done_o(done)
  );

  int unsigned n_chk = 0, n_bad = 0;
  longint      cyc = 0;
  bit          ended = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint unsigned q_a[$], q_b[$], q_m[$];
  longint          q_iss[$];
  string           q_tag[$];
  longint unsigned cur_b, cur_m;
  longint unsigned got_r = 0;
  int              exp_pos = 0;

  task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rst_n && res_vld && q_a.size() != 0) begin
      if (res_pos == '0) begin
        got_r   = 0;
        exp_pos = 0;
      end
      chk(int'(res_pos) == exp_pos, "R5 order", res_pos, exp_pos);
      chk(cyc == q_iss[0] + longint'(res_pos) + 1, "R5 latency", cyc, q_iss[0] + res_pos + 1);
      chk(done == (int'(res_pos) == N - 1), "R6", done, int'(res_pos) == N - 1);
      got_r = got_r | (longint'(res_dig) << (int'(res_pos) * K));
      exp_pos++;
      if (done) begin
        longint unsigned lhs, rhs;
        lhs = (got_r << (K * N)) % q_m[0];
        rhs = (q_a[0] * q_b[0]) % q_m[0];
        chk(lhs == rhs, {"R2/", q_tag[0]}, lhs, rhs);
        chk(got_r < 2 * q_m[0], "R3", got_r, 2 * q_m[0]);
        void'(q_a.pop_front()); void'(q_b.pop_front()); void'(q_m.pop_front());
        void'(q_iss.pop_front()); void'(q_tag.pop_front());
      end
    end else if (rst_n && res_vld) begin
      chk(1'b0, "R1 unexpected result", res_vld, 0);
    end
  end

  task automatic push_exp(longint unsigned a, string tag);
    q_a.push_back(a); q_b.push_back(cur_b); q_m.push_back(cur_m);
    q_iss.push_back(cyc + 1); q_tag.push_back(tag);
  endtask

  task automatic drain_wait();
    while (q_a.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_cfg(longint unsigned m, longint unsigned b);
    int inv = 1;
    drain_wait();
    for (int x = 1; x < 16; x++) if (((m & 15) * x & 15) == 1) inv = x;
    cur_m = m; cur_b = b;
    @(negedge clk);
    cfg_ld = 1'b1; cfg_m = OPW'(m); cfg_b = OPW'(b); cfg_ninv = K'((16 - inv) & 15);
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic send_a(longint unsigned a, int gap, string tag);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      a_vld = 1'b1; a_dig = a[i*K +: K];
      if (i == N - 1) push_exp(a, tag);
      @(negedge clk);
      a_vld = 1'b0;
      for (int g = 2; g < gap; g++) @(negedge clk);
    end
  endtask

  // a digit offered every cycle: odd offers must be dropped (R4)
  task automatic send_burst(longint unsigned a);
    for (int o = 0; o < 2 * N; o++) begin
      @(negedge clk);
      a_vld = 1'b1;
      a_dig = (o % 2 == 0) ? a[(o/2)*K +: K] : K'($urandom_range(1, 15));
      if (o == 2 * N - 2) push_exp(a, "R4");
    end
    @(negedge clk);
    a_vld = 1'b0;
  endtask

  function automatic longint unsigned rnd_a();
    return longint'($urandom) % (64'd1 << (K * (N - 1)));
  endfunction

  initial begin
    rst_n = 1'b0; cfg_ld = 1'b0; cfg_b = '0; cfg_m = '0; cfg_ninv = '0;
    a_vld = 1'b0; a_dig = '0;
    repeat (4) @(negedge clk);
    chk(!res_vld && !done, "R1 in reset", {res_vld, done}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!res_vld && !done, "R1 after reset", {res_vld, done}, 0);
    end
    for (int idx = 0; idx < 120; idx++) begin
      longint unsigned m, b, a1;
      if (idx == 0)      begin m = 3;                 b = 5;     end
      else if (idx == 1) begin m = (64'd1 << 27) - 1; b = 2 * m - 1; end
      else if (idx == 2) begin m = (64'd1 << 27) - 1; b = 0;     end
      else begin
        m = (3 + longint'($urandom) % ((64'd1 << 27) - 3)) | 1;
        b = longint'($urandom) % (2 * m);
      end
      load_cfg(m, b);
      if (idx % 4 == 0)      a1 = 0;
      else if (idx % 4 == 1) a1 = (64'd1 << (K * (N - 1))) - 1;
      else                   a1 = rnd_a();
      send_a(a1, 2, "R8");
      send_a(rnd_a(), 2, "R7");
      send_a(rnd_a(), 3 + idx % 3, "R9");
      send_burst(rnd_a());
    end
    drain_wait();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule